// File: doc/BRIEF.md
# USB Host Frame-End Interrupt Status

This block sits beside the transfer engine of a USB host controller. While a frame is in progress, the engine reports per-transaction outcomes as single-cycle pulses:
- a completed descriptor carrying the completion-interrupt flag;
- a short packet on a descriptor carrying the short-detect flag;
- a completion that ended in a timeout or CRC error;
- babble;
- a stall;
- a data-buffer error whose retry count has run out.

These outcomes are held as pending for the rest of the frame. On the end-of-frame strobe they are committed into a two-bit host status register. Software sees nothing before the frame boundary.

The IOC pulse is meant to arrive whenever the engine evaluates a flagged descriptor whose active flag is 0. That includes a descriptor that was already inactive when it was first fetched. The block treats every pulse alike and does not check this.

A level interrupt line is formed from the committed status and an interrupt-enable register, with a separate enable for each event class. Babble, stall and exhausted buffer errors always interrupt. Software reads both registers through a small register port. It clears status bits by writing 1 to them.

Top module: `usbh_frame_irq`

## Requirements
- R1: Events never change the status register during the frame. Status bits change only in the cycle after a cycle with `frame_end` high.
- R2: An IOC event sets status bit 0 (general interrupt) at frame end. It drives `irq` high only while enable bit 2 is 1.
- R3: A short-packet event sets status bit 0 at frame end. It drives `irq` high only while enable bit 3 is 1.
- R4: An error completion sets both status bit 0 and status bit 1 (error) at frame end. It drives `irq` high only while enable bit 0 is 1.
- R5: Babble, stall and retry-exhausted buffer errors each set status bit 1 only, at frame end. They drive `irq` high whatever the enables hold.
- R6: A write to offset 2 clears each status bit written with 1, in the next cycle. Bits written with 0 are left unchanged.
- R7: If a frame-end commit sets a status bit in the same cycle as a write that clears it, the bit stays set.
- R8: An event pulsed in the same cycle as `frame_end` belongs to the ending frame. Pending events are emptied at every `frame_end`, so a later `frame_end` with no new events sets nothing.
- R9: `irq` is a level formed from the registers. It stays high across frames until the causing status bit is cleared. Raising an enable bit for an already-committed cause raises `irq` in the next cycle.
- R10: After reset, both status bits, the enable register and `irq` are 0, and no events are pending.
- R11: The enable register sits at offset 4. Only bits 0, 2 and 3 are stored, and all other bits read as 0. Status reads at offset 2 return the error bit in bit 1 and the general bit in bit 0. Reads at other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_ioc | input | 1 | Completed descriptor with its completion-interrupt flag |
| ev_short | input | 1 | Short packet on a descriptor with its short-detect flag |
| ev_err | input | 1 | Completion ended by a timeout or CRC error |
| ev_babble | input | 1 | Device babble detected |
| ev_stall | input | 1 | Stall handshake or fatal transaction error |
| ev_bufx | input | 1 | Buffer overrun or underrun with the retry count exhausted |
| frame_end | input | 1 | End-of-frame strobe, one cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (3) | Register byte offset |
| reg_wdata | input | DW (8) | Register write data |
| reg_rdata | output | DW (8) | Register read data, combinational from `reg_addr` |
| sts_usbint | output | 1 | General interrupt status bit |
| sts_usberr | output | 1 | Error interrupt status bit |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a frame-end commit that lands on the same edge as a software clear of the same bit. To reach it, the bench first commits an IOC so the bit is already set. It then pulses a fresh IOC in the next frame and drives the clearing write together with the strobe. Only that case tells set-wins priority apart from clear-wins.

A second hard case is an event arriving exactly in the strobe cycle. The bench drives it together with `frame_end`, then follows with an empty frame to show the pending store was emptied.

// File: rtl/usbh_irq_pkg.sv
// Package: shared types and bit positions for the frame-end interrupt block.
// Assumes: status and enable bit positions are fixed by the software view.
package usbh_irq_pkg;

    // One transfer-engine report, each field a single-cycle pulse
    typedef struct packed {
        logic bufx;
        logic stall;
        logic babble;
        logic err;
        logic spd;
        logic ioc;
    } usb_evt_t;

    // Internal cause classes, one flag each
    localparam int C_IOC   = 0;  // completion with interrupt flag
    localparam int C_SPD   = 1;  // short packet
    localparam int C_EINT  = 2;  // error completion, general-status part
    localparam int C_ESOFT = 3;  // error completion, error-status part
    localparam int C_EHARD = 4;  // babble / stall / retries exhausted
    localparam int NCAUSE  = 5;

    // Status register layout
    localparam int STS_INT_BIT = 0;
    localparam int STS_ERR_BIT = 1;

    // Enable register layout
    localparam int EN_W       = 4;
    localparam int EN_ERR_BIT = 0;
    localparam int EN_IOC_BIT = 2;
    localparam int EN_SPD_BIT = 3;
    localparam logic [EN_W-1:0] EN_MASK =
        EN_W'((1 << EN_ERR_BIT) | (1 << EN_IOC_BIT) | (1 << EN_SPD_BIT));

endpackage

// File: rtl/usbh_evt_pend.sv
// Module: usbh_evt_pend
// Collects event pulses into per-class pending flags during a frame.
// At frame_end it presents pending plus same-cycle events for commit,
// then empties the pending store.
// Assumes: event pulses are one cycle wide and synchronous to clk.
module usbh_evt_pend
    import usbh_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  usb_evt_t          ev,
    input  logic              frame_end,
    output logic              commit,
    output logic [NCAUSE-1:0] frame_cause
);

    logic [NCAUSE-1:0] ev_cause;
    logic [NCAUSE-1:0] pend_q;

    // Map raw event pulses onto cause classes
    always_comb begin
        ev_cause          = '0;
        ev_cause[C_IOC]   = ev.ioc;
        ev_cause[C_SPD]   = ev.spd;
        ev_cause[C_EINT]  = ev.err;
        ev_cause[C_ESOFT] = ev.err;
        ev_cause[C_EHARD] = ev.babble | ev.stall | ev.bufx;
    end

    // Accumulate pending causes; empty them on the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= '0;
        else if (frame_end) pend_q <= '0;
        else                pend_q <= pend_q | ev_cause;
    end

    // Causes of the ending frame include events in the strobe cycle
    always_comb begin
        commit      = frame_end;
        frame_cause = pend_q | ev_cause;
    end

    // R8
    pend_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (pend_q == '0));

endmodule

// File: rtl/usbh_sts_reg.sv
// Module: usbh_sts_reg
// Holds one flag per cause class. Flags are set on commit and cleared
// by write-1-to-clear in their status group; a commit wins over a clear.
// Derives the two visible status bits from the flags.
// Assumes: clr_int / clr_err are already decoded from a status write.
module usbh_sts_reg
    import usbh_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [NCAUSE-1:0] frame_cause,
    input  logic              clr_int,
    input  logic              clr_err,
    output logic              sts_int,
    output logic              sts_err,
    output logic              f_ioc,
    output logic              f_spd,
    output logic              f_esoft,
    output logic              f_ehard
);

    localparam logic [NCAUSE-1:0] ERR_GRP =
        NCAUSE'((1 << C_ESOFT) | (1 << C_EHARD));

    logic [NCAUSE-1:0] flag_q;
    logic [NCAUSE-1:0] grp_clr;
    logic              int_set;

    // Route each flag to the clear strobe of its status group
    always_comb begin
        for (int i = 0; i < NCAUSE; i++)
            grp_clr[i] = ERR_GRP[i] ? clr_err : clr_int;
    end

    for (genvar i = 0; i < NCAUSE; i++) begin : g_flag
        // One cause flag: commit sets it, otherwise a group clear resets it
        always_ff @(posedge clk) begin
            if (!rst_n)                      flag_q[i] <= 1'b0;
            else if (commit && frame_cause[i]) flag_q[i] <= 1'b1;
            else if (grp_clr[i])             flag_q[i] <= 1'b0;
        end
    end

    // Visible status bits and the flags the interrupt gate needs
    always_comb begin
        sts_int = flag_q[C_IOC] | flag_q[C_SPD] | flag_q[C_EINT];
        sts_err = flag_q[C_ESOFT] | flag_q[C_EHARD];
        f_ioc   = flag_q[C_IOC];
        f_spd   = flag_q[C_SPD];
        f_esoft = flag_q[C_ESOFT];
        f_ehard = flag_q[C_EHARD];
        int_set = commit & (frame_cause[C_IOC] | frame_cause[C_SPD] |
                            frame_cause[C_EINT]);
    end

    // R1
    int_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_int) |-> $past(commit));

    // R1
    err_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_err) |-> $past(commit));

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int && !int_set) |=> !sts_int);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frame_cause[C_IOC] && clr_int) |=> sts_int);

endmodule

// File: rtl/usbh_irq_gate.sv
// Module: usbh_irq_gate
// Stores the interrupt-enable register and forms the level interrupt
// from the committed cause flags. Hard errors bypass the enables.
// Assumes: en_wdata is only sampled when en_wr is high.
module usbh_irq_gate
    import usbh_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr,
    input  logic [EN_W-1:0] en_wdata,
    input  logic            f_ioc,
    input  logic            f_spd,
    input  logic            f_esoft,
    input  logic            f_ehard,
    output logic [EN_W-1:0] en_q,
    output logic            irq
);

    // Enable register: only the defined bits are stored
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata & EN_MASK;
    end

    // Level interrupt: each gated cause, plus ungated hard errors
    always_comb begin
        irq = (f_ioc   & en_q[EN_IOC_BIT]) |
              (f_spd   & en_q[EN_SPD_BIT]) |
              (f_esoft & en_q[EN_ERR_BIT]) |
              f_ehard;
    end

    // R11
    en_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~EN_MASK) == '0);

    // R5
    hard_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_ehard) |-> irq);

endmodule

// File: rtl/usbh_frame_irq.sv
// Module: usbh_frame_irq (top)
// Frame-end interrupt status for a USB host: pending collection,
// status register with write-1-to-clear, and gated level interrupt.
// Assumes: byte offsets STS_OFS / EN_OFS select the two registers and
// DW is at least EN_W bits wide.
module usbh_frame_irq
    import usbh_irq_pkg::*;
#(
    parameter int            DW      = 8,
    parameter int            AW      = 3,
    parameter logic [AW-1:0] STS_OFS = AW'(2),
    parameter logic [AW-1:0] EN_OFS  = AW'(4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_ioc,
    input  logic          ev_short,
    input  logic          ev_err,
    input  logic          ev_babble,
    input  logic          ev_stall,
    input  logic          ev_bufx,
    input  logic          frame_end,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          sts_usbint,
    output logic          sts_usberr,
    output logic          irq
);

    localparam int PAD_W = DW - EN_W;

    usb_evt_t          ev;
    logic              commit;
    logic [NCAUSE-1:0] frame_cause;
    logic              wr_sts, wr_en;
    logic              clr_int, clr_err;
    logic              f_ioc, f_spd, f_esoft, f_ehard;
    logic [EN_W-1:0]   en_q;
    logic [DW-1:0]     sts_word;
    logic              wdata_unused;

    // Pack event pins and decode register writes
    always_comb begin
        ev.ioc    = ev_ioc;
        ev.spd    = ev_short;
        ev.err    = ev_err;
        ev.babble = ev_babble;
        ev.stall  = ev_stall;
        ev.bufx   = ev_bufx;
        wr_sts    = reg_wr && (reg_addr == STS_OFS);
        wr_en     = reg_wr && (reg_addr == EN_OFS);
        clr_int   = wr_sts && reg_wdata[STS_INT_BIT];
        clr_err   = wr_sts && reg_wdata[STS_ERR_BIT];
    end

    assign wdata_unused = ^reg_wdata[DW-1:EN_W];

    usbh_evt_pend u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .frame_end   (frame_end),
        .commit      (commit),
        .frame_cause (frame_cause)
    );

    usbh_sts_reg u_sts (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .frame_cause (frame_cause),
        .clr_int     (clr_int),
        .clr_err     (clr_err),
        .sts_int     (sts_usbint),
        .sts_err     (sts_usberr),
        .f_ioc       (f_ioc),
        .f_spd       (f_spd),
        .f_esoft     (f_esoft),
        .f_ehard     (f_ehard)
    );

    usbh_irq_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (wr_en),
        .en_wdata (reg_wdata[EN_W-1:0]),
        .f_ioc    (f_ioc),
        .f_spd    (f_spd),
        .f_esoft  (f_esoft),
        .f_ehard  (f_ehard),
        .en_q     (en_q),
        .irq      (irq)
    );

    // Read mux: status word, enable word, or zero
    always_comb begin
        sts_word              = '0;
        sts_word[STS_INT_BIT] = sts_usbint;
        sts_word[STS_ERR_BIT] = sts_usberr;
        if (reg_addr == STS_OFS)     reg_rdata = sts_word;
        else if (reg_addr == EN_OFS) reg_rdata = {{PAD_W{1'b0}}, en_q};
        else                         reg_rdata = '0;
    end

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts_usbint || sts_usberr));

endmodule

// File: tb/usbh_frame_irq_bench.sv
module usbh_frame_irq_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ev_ioc, ev_short, ev_err, ev_babble, ev_stall, ev_bufx;
    logic       frame_end;
    logic       reg_wr;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       sts_usbint, sts_usberr, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    usbh_frame_irq u_usbh_frame_irq (
        .clk(clk), .rst_n(rst_n),
        .ev_ioc(ev_ioc), .ev_short(ev_short), .ev_err(ev_err),
        .ev_babble(ev_babble), .ev_stall(ev_stall), .ev_bufx(ev_bufx),
        .frame_end(frame_end), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sts_usbint(sts_usbint), .sts_usberr(sts_usberr), .irq(irq)
    );

    // Vector: {events[5:0] = bufx,stall,babble,err,short,ioc ; enable[3:0] ;
    //          expected status {err,int} ; expected irq}
    localparam int NV = 12;
    localparam logic [12:0] VEC [NV] = '{
        13'b000001_0000_01_0,  // R2 ioc, no enable
        13'b000001_0100_01_1,  // R2 ioc, ioc enable
        13'b000010_0100_01_0,  // R3 short, wrong enable
        13'b000010_1000_01_1,  // R3 short, short enable
        13'b000100_0000_11_0,  // R4 error, no enable
        13'b000100_0001_11_1,  // R4 error, error enable
        13'b001000_0000_10_1,  // R5 babble
        13'b010000_0000_10_1,  // R5 stall
        13'b100000_0000_10_1,  // R5 buffer retries exhausted
        13'b000011_1000_01_1,  // R3 ioc+short, short enable only
        13'b000000_1101_00_0,  // R1 empty frame
        13'b000001_1011_01_0   // R2 ioc, every enable but ioc
    };

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        {ev_bufx, ev_stall, ev_babble, ev_err, ev_short, ev_ioc} = '0;
        frame_end = 1'b0;
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic set_ev(logic [5:0] e);
        {ev_bufx, ev_stall, ev_babble, ev_err, ev_short, ev_ioc} = e;
    endtask

    task automatic wr_reg(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic pulse_ev(logic [5:0] e);
        @(negedge clk);
        set_ev(e);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        idle_inputs();
    endtask

    function automatic string tag_of(logic [5:0] e);
        if (e[0])      return "R2";
        if (e[1])      return "R3";
        if (e[2])      return "R4";
        if (e[5:3] != 0) return "R5";
        return "R1";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_addr = 3'd2;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 status", {6'b0, sts_usberr, sts_usbint}, 8'h00);
        chk("R10 irq", {7'b0, irq}, 8'h00);
        reg_addr = 3'd4; #1;
        chk("R10 enable read", reg_rdata, 8'h00);
        reg_addr = 3'd2; #1;
        chk("R10 status read", reg_rdata, 8'h00);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [5:0] e;
            logic [3:0] en;
            logic [1:0] xs;
            logic       xi;
            {e, en, xs, xi} = VEC[v];
            wr_reg(3'd4, {4'b0, en});
            pulse_ev(e);
            chk("R1 before frame end", {6'b0, sts_usberr, sts_usbint}, 8'h00);
            pulse_frame();
            chk({tag_of(e), " status"}, {6'b0, sts_usberr, sts_usbint}, {6'b0, xs});
            chk({tag_of(e), " irq"}, {7'b0, irq}, {7'b0, xi});
            wr_reg(3'd2, 8'h03);
            chk("R6 cleared", {6'b0, sts_usberr, sts_usbint}, 8'h00);
        end

        // R1 event held several cycles without strobe
        wr_reg(3'd4, 8'h0D);
        pulse_ev(6'b000001);
        repeat (4) @(negedge clk);
        chk("R1 held pending", {6'b0, sts_usberr, sts_usbint, irq}, 8'h00);
        pulse_frame();
        chk("R1 committed", {6'b0, sts_usbint, irq}, 8'h03);
        wr_reg(3'd2, 8'h01);

        // R4 status read layout after error completion
        pulse_ev(6'b000100);
        pulse_frame();
        reg_addr = 3'd2; #1;
        chk("R4 status read", reg_rdata, 8'h03);
        wr_reg(3'd2, 8'h03);

        // R6 write-1-to-clear per bit
        pulse_ev(6'b001000);
        pulse_frame();
        wr_reg(3'd2, 8'h00);
        chk("R6 write zero", {6'b0, sts_usberr, irq}, 8'h03);
        wr_reg(3'd2, 8'h01);
        chk("R6 other bit", {6'b0, sts_usberr, irq}, 8'h03);
        wr_reg(3'd2, 8'h02);
        chk("R6 clear err", {6'b0, sts_usberr, irq}, 8'h00);

        // R7 commit and clear in the same cycle
        pulse_ev(6'b000001);
        pulse_frame();
        pulse_ev(6'b000001);
        @(negedge clk);
        frame_end = 1'b1; reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h01;
        @(negedge clk);
        idle_inputs();
        chk("R7 set wins", {7'b0, sts_usbint}, 8'h01);
        wr_reg(3'd2, 8'h01);
        chk("R6 clear after R7", {7'b0, sts_usbint}, 8'h00);

        // R8 event in the strobe cycle, then empty frame
        @(negedge clk);
        ev_short = 1'b1; frame_end = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk("R8 strobe-cycle event", {7'b0, sts_usbint}, 8'h01);
        wr_reg(3'd2, 8'h03);
        pulse_frame();
        chk("R8 pending emptied", {6'b0, sts_usberr, sts_usbint}, 8'h00);

        // R9 level behaviour and late enable
        wr_reg(3'd4, 8'h00);
        pulse_ev(6'b000001);
        pulse_frame();
        pulse_frame();
        chk("R9 gated off", {6'b0, sts_usbint, irq}, 8'h02);
        wr_reg(3'd4, 8'h04);
        chk("R9 late enable", {7'b0, irq}, 8'h01);
        pulse_frame();
        pulse_frame();
        chk("R9 level held", {7'b0, irq}, 8'h01);
        wr_reg(3'd2, 8'h01);
        chk("R9 drop on clear", {7'b0, irq}, 8'h00);

        // R11 enable masking and unmapped offset
        wr_reg(3'd4, 8'hFF);
        reg_addr = 3'd4; #1;
        chk("R11 enable mask", reg_rdata, 8'h0D);
        reg_addr = 3'd6; #1;
        chk("R11 unmapped read", reg_rdata, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule